// File: doc/BRIEF.md
# NaN Result Selector for Single-Precision Operations

This block decides which NaN a two-operand single-precision arithmetic operation returns when at least one operand is a NaN. Each 32-bit operand is classed as quiet NaN, signaling NaN or ordinary value. One operand is then chosen under a policy named by a 2-bit mode input. The chosen value is made quiet before it leaves the block. A separate control forces the fixed default NaN instead. An invalid-operation flag marks any case with a signaling NaN among the operands.

An arithmetic datapath uses it as the NaN side path. The datapath detects a NaN operand, hands both operands and the current policy to this block, and takes the result in place of its own. A parameter selects whether the output is registered, which gives one cycle of latency, or combinational.

Top module: `nan_sel32`

## Requirements
- R1: An operand is a signaling NaN when bits 30..23 are all ones, bit 22 is clear and bits 21..0 are not all zero. It is a quiet NaN when bits 30..23 are all ones and bit 22 is set. All ones in bits 30..23 with a zero fraction is an infinity, which is not a NaN.
- R2: When `dflt_en` is high, `res_o` is 0x7FC00000 whatever the operands are.
- R3: `inv_o` is high exactly when at least one operand is a signaling NaN. This holds in default-NaN mode too.
- R4: With `policy` = 0, the first match in this list is chosen: A if it is signaling, B if it is signaling, A if it is quiet, and otherwise B.
- R5: With `policy` = 1, the order of choice is the same as in R4, and the quiet bit is the same bit 22.
- R6: With `policy` = 2, A is chosen if it is a NaN of either kind, and otherwise B is chosen.
- R7: With `policy` = 3 and operands of different kinds, a quiet NaN wins over a signaling NaN, and any NaN wins over a non-NaN.
- R8: With `policy` = 3 and two NaNs of the same kind, the operand whose bits 30..0 form the larger unsigned value wins, so the sign is ignored. When those bits are equal, the operand with sign 0 wins.
- R9: The result equals the chosen operand with bit 22 forced to 1, and its sign and other fraction bits are kept.
- R10: With `REG_OUT` = 1, a request presented with `vld_i` appears on the outputs one cycle later with `vld_o` high. Reset clears `vld_o`, `res_o` and `inv_o` to zero, and `vld_o` is low in any cycle after a cycle with `vld_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Request valid |
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B) |
| policy | input | 2 | 0, 1, 2 or 3, selecting the policy of R4, R5, R6 or R7/R8 |
| dflt_en | input | 1 | Force the default NaN result |
| vld_o | output | 1 | Result valid |
| res_o | output | 32 | Quiet NaN result |
| inv_o | output | 1 | Invalid-operation flag |

## Verification
The hardest case to reach is the tie-break under policy 3. It needs two NaNs of the same kind whose bits 30..0 match exactly, so that only the sign decides the winner. The stimulus builds such pairs with the negative copy on each side in turn. It also sends a pair in which the negative NaN has the larger fraction, to show that the sign is dropped before the comparison. Signaling and quiet operands are also placed in each position under every policy, so that each ordering rule is forced into a different winner.

// File: rtl/nan_sel32.sv
module nan_sel32 #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vld_i,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [1:0]  policy,
  input  logic        dflt_en,
  output logic        vld_o,
  output logic [31:0] res_o,
  output logic        inv_o
);
  localparam int          QBIT     = 22;
  localparam int          EXP_LSB  = 23;
  localparam int          EXP_MSB  = 30;
  localparam logic [31:0] DFLT_NAN = 32'h7FC0_0000;
  localparam logic [31:0] QMASK    = 32'h1 << QBIT;

  logic a_top, b_top, a_nan, b_nan, a_q, b_q, a_s, b_s;
  logic [31:0] a_mag, b_mag;
  logic a_big, pick_b;
  logic [31:0] nxt_res;
  logic nxt_inv;

  assign a_top = &op_a[EXP_MSB:EXP_LSB];
  assign b_top = &op_b[EXP_MSB:EXP_LSB];
  assign a_nan = a_top & (|op_a[QBIT:0]);
  assign b_nan = b_top & (|op_b[QBIT:0]);
  assign a_q   = a_top & op_a[QBIT];
  assign b_q   = b_top & op_b[QBIT];
  assign a_s   = a_nan & ~op_a[QBIT];
  assign b_s   = b_nan & ~op_b[QBIT];

  assign a_mag = {op_a[30:0], 1'b0};
  assign b_mag = {op_b[30:0], 1'b0};
  assign a_big = (a_mag > b_mag) | ((a_mag == b_mag) & (op_a < op_b));

  always_comb begin
    unique case (policy)
      2'd0, 2'd1: begin
        if (a_s)      pick_b = 1'b0;
        else if (b_s) pick_b = 1'b1;
        else if (a_q) pick_b = 1'b0;
        else          pick_b = 1'b1;
      end
      2'd2: pick_b = ~a_nan;
      default: begin
        if (a_s)      pick_b = b_s ? ~a_big : b_q;
        else if (a_q) pick_b = (b_s | ~b_q) ? 1'b0 : ~a_big;
        else          pick_b = 1'b1;
      end
    endcase
  end

  assign nxt_inv = a_s | b_s;
  assign nxt_res = (dflt_en | ~(a_nan | b_nan)) ? DFLT_NAN
                 : ((pick_b ? op_b : op_a) | QMASK);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_o <= 1'b0;
          res_o <= '0;
          inv_o <= 1'b0;
        end else begin
          vld_o <= vld_i;
          res_o <= nxt_res;
          inv_o <= nxt_inv;
        end
      end
    end else begin : g_comb
      assign vld_o = vld_i;
      assign res_o = nxt_res;
      assign inv_o = nxt_inv;
    end
  endgenerate
endmodule

// File: rtl/nan_sel32_chk.sv
module nan_sel32_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        vld_i,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [1:0]  policy,
  input logic        dflt_en,
  input logic        vld_o,
  input logic [31:0] res_o,
  input logic        inv_o
);
  logic        s_vld, s_dflt;
  logic [31:0] s_a, s_b;
  logic [1:0]  s_pol;

  generate
    if (REG_OUT) begin : g_seen
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_vld <= 1'b0; s_dflt <= 1'b0; s_a <= '0; s_b <= '0; s_pol <= '0;
        end else begin
          s_vld <= vld_i; s_dflt <= dflt_en; s_a <= op_a; s_b <= op_b; s_pol <= policy;
        end
      end
    end else begin : g_direct
      assign s_vld = vld_i; assign s_dflt = dflt_en;
      assign s_a = op_a; assign s_b = op_b; assign s_pol = policy;
    end
  endgenerate

  logic sa_sig, sb_sig, sa_any;
  assign sa_sig = (s_a[30:23] == 8'hFF) && !s_a[22] && (s_a[21:0] != 22'd0);
  assign sb_sig = (s_b[30:23] == 8'hFF) && !s_b[22] && (s_b[21:0] != 22'd0);
  assign sa_any = (s_a[30:23] == 8'hFF) && (s_a[22:0] != 23'd0);

  assert_quiet_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (res_o[30:23] == 8'hFF) && res_o[22]);

  assert_dflt_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && s_dflt) |-> res_o == 32'h7FC0_0000);

  assert_inv_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> inv_o == (sa_sig || sb_sig));

  assert_first_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !s_dflt && s_pol == 2'd2 && sa_any) |-> res_o == (s_a | 32'h0040_0000));

  assert_sig_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !s_dflt && s_pol == 2'd0 && sa_sig) |-> res_o == (s_a | 32'h0040_0000));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_vld |-> !vld_o);
endmodule

bind nan_sel32 nan_sel32_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_a(op_a), .op_b(op_b),
  .policy(policy), .dflt_en(dflt_en), .vld_o(vld_o), .res_o(res_o), .inv_o(inv_o)
);

// File: tb/nan_sel32_tb_top.sv
`timescale 1ns/1ps
module nan_sel32_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, vld_i, dflt_en, vld_o, inv_o;
  logic [31:0] op_a, op_b, res_o;
  logic [1:0]  policy;

  nan_sel32 #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_a(op_a), .op_b(op_b),
    .policy(policy), .dflt_en(dflt_en), .vld_o(vld_o), .res_o(res_o), .inv_o(inv_o)
  );

  logic [31:0] q_res[$];
  logic        q_inv[$];
  string       q_tag[$];
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [31:0] SA  = 32'h7F80_0005;
  localparam logic [31:0] SB  = 32'h7F80_0009;
  localparam logic [31:0] QA  = 32'h7FC0_0003;
  localparam logic [31:0] QB  = 32'h7FC0_0007;
  localparam logic [31:0] ONE = 32'h3F80_0000;

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [1:0] pol,
                      input logic dflt, input logic [31:0] er, input logic ei, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; policy = pol; dflt_en = dflt; vld_i = 1'b1;
    q_res.push_back(er); q_inv.push_back(ei); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && vld_o) begin
      n_chk++;
      if (q_res.size() == 0) begin
        n_fail++;
        $display("FAIL R10: unexpected result res=%h, expected none", res_o);
      end else begin
        logic [31:0] er;
        logic ei;
        string tag;
        er = q_res.pop_front(); ei = q_inv.pop_front(); tag = q_tag.pop_front();
        if (res_o !== er || inv_o !== ei) begin
          n_fail++;
          $display("FAIL %s: res=%h inv=%b, expected res=%h inv=%b", tag, res_o, inv_o, er, ei);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vld_i = 1'b0; op_a = '0; op_b = '0; policy = '0; dflt_en = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (vld_o !== 1'b0 || res_o !== 32'h0 || inv_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: vld=%b res=%h inv=%b, expected 0 0 0", vld_o, res_o, inv_o);
    end
    rst_n = 1'b1;

    send(QA, SB, 2'd0, 1'b0, 32'h7FC0_0009, 1'b1, "R4 signaling B beats quiet A");
    send(SA, SB, 2'd0, 1'b0, 32'h7FC0_0005, 1'b1, "R4 signaling A first");
    send(QA, QB, 2'd0, 1'b0, 32'h7FC0_0003, 1'b0, "R4 quiet A over quiet B");
    send(ONE, QB, 2'd0, 1'b0, 32'h7FC0_0007, 1'b0, "R4 B when A is a number");
    send(QA, SB, 2'd1, 1'b0, 32'h7FC0_0009, 1'b1, "R5 signaling B beats quiet A");
    send(QA, ONE, 2'd1, 1'b0, 32'h7FC0_0003, 1'b0, "R5 quiet A over number");
    send(QA, SB, 2'd2, 1'b0, 32'h7FC0_0003, 1'b1, "R6 A NaN wins");
    send(ONE, SB, 2'd2, 1'b0, 32'h7FC0_0009, 1'b1, "R6 B when A not NaN");
    send(SA, QB, 2'd3, 1'b0, 32'h7FC0_0007, 1'b1, "R7 quiet B over signaling A");
    send(QA, SB, 2'd3, 1'b0, 32'h7FC0_0003, 1'b1, "R7 quiet A over signaling B");
    send(SA, ONE, 2'd3, 1'b0, 32'h7FC0_0005, 1'b1, "R7 signaling NaN over number");
    send(ONE, QB, 2'd3, 1'b0, 32'h7FC0_0007, 1'b0, "R7 quiet NaN over number");
    send(QA, QB, 2'd3, 1'b0, 32'h7FC0_0007, 1'b0, "R8 larger quiet significand");
    send(SA, SB, 2'd3, 1'b0, 32'h7FC0_0009, 1'b1, "R8 larger signaling significand");
    send(32'hFFC0_0003, QA, 2'd3, 1'b0, 32'h7FC0_0003, 1'b0, "R8 tie positive B");
    send(QA, 32'hFFC0_0003, 2'd3, 1'b0, 32'h7FC0_0003, 1'b0, "R8 tie positive A");
    send(32'hFFC0_0008, QB, 2'd3, 1'b0, 32'hFFC0_0008, 1'b0, "R8 sign ignored in compare");
    send(SA, QB, 2'd0, 1'b1, 32'h7FC0_0000, 1'b1, "R2 R3 default NaN forced");
    send(32'h7F80_0000, QB, 2'd2, 1'b0, 32'h7FC0_0007, 1'b0, "R1 infinity is not NaN");
    send(32'h7FC0_0000, SB, 2'd2, 1'b0, 32'h7FC0_0000, 1'b1, "R1 zero-fraction quiet NaN");
    send(32'hFF80_0001, QB, 2'd0, 1'b0, 32'hFFC0_0001, 1'b1, "R9 sign and fraction kept");
    idle();
    idle();
    n_chk++;
    if (vld_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 idle: vld=%b, expected 0", vld_o);
    end
    repeat (2) @(negedge clk);
    n_chk++;
    if (q_res.size() != 0) begin
      n_fail++;
      $display("FAIL R10 drain: %0d results missing, expected 0", q_res.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule